// File: doc/BRIEF.md
# Lockable Cache Way Replacement Selector

This block picks the way that a four-way set-associative cache evicts when a line fill starts. Software can lock any of the four ways with a per-way mask, and a locked way is never offered as a victim. A mode bit chooses between two policies:

- **Round-robin:** a rotating pointer gives the starting way.
- **Pseudo-random:** a free-running linear feedback shift register gives the starting way.

In both policies the search then moves upward past locked ways to the first free way, wrapping from way 3 back to way 0. A cache-enable bit stops all victim output while the cache is off.

Each accepted fill request produces a one-cycle victim pulse with the chosen way index, one clock after the request. Internally a two-state controller runs the output pulse:

- **SEL_IDLE:** no victim is being shown. It moves to SEL_ISSUE on an accepted request and otherwise stays.
- **SEL_ISSUE:** the victim is shown. It stays on a further accepted request and returns to SEL_IDLE otherwise.

Top module: `vsel_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `victim_valid` is 0 and `victim_way` is 0. Reset sets the round-robin pointer to way 0, so the first round-robin victim with no locks is way 0.
- R2: A request is accepted when all three of these hold in the same cycle:
  - `fill_req` is 1;
  - `cache_on` is 1;
  - at least one `lock_mask` bit is 0.

  After every accepted request, `victim_valid` is 1 in the next cycle and only in that cycle. With no accepted request it is 0 in the next cycle.
- R3: Bit i of `lock_mask` locks way i. A reported victim never names a way whose lock bit was 1 in the request cycle.
- R4: With `rand_mode`=0, the victim is the first unlocked way found by scanning upward from the pointer and wrapping 3→0. After issuing, the pointer becomes the chosen way plus 1, modulo 4.
- R5: The round-robin pointer changes only when a round-robin victim is issued. Requests made in random mode, requests that are rejected, and idle cycles leave it unchanged.
- R6: With `rand_mode`=1, the start way is bits [1:0] of an 8-bit register, and the scan skips locked ways upward with wrap. The register behaves as follows:
  - Reset sets it to 8'hA5.
  - Every clock after reset it shifts left by one bit.
  - The bit shifted in at bit 0 is the XOR of bits 7, 5, 4 and 3 (polynomial x^8+x^6+x^5+x^4+1).
  - Requests do not affect it.
- R7: When all four `lock_mask` bits are 1, a request yields no victim.
- R8: When `cache_on` is 0, a request yields no victim and changes no pointer.
- R9: A change of `rand_mode` applies to the very next request, and neither the pointer nor the shift register is reset by the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_req | input | 1 | Line-fill request strobe, one request per cycle high |
| lock_mask | input | 4 | Bit i = 1 locks way i |
| rand_mode | input | 1 | 1 = pseudo-random, 0 = round-robin |
| cache_on | input | 1 | Cache enable; 0 suppresses victims |
| victim_way | output | 2 | Chosen way, meaningful while `victim_valid` is 1 |
| victim_valid | output | 1 | One-cycle pulse per accepted request |

## Verification
The bench targets the following corner cases, and what a faulty design would show in each:

- **Wrapping scan:** a pointer or random start on a locked way must move to the next free way above it, wrapping past way 3. A design that wraps wrongly or accepts the locked way reports a forbidden index.
- **Fully locked mask and disabled cache:** a design that still pulses, or that advances the pointer on these rejected requests, shows either a stray valid or a shifted round-robin sequence afterwards.
- **Random-mode requests:** these must not touch the pointer.
- **Shift register timing:** it must run every cycle, so a design that steps it only on requests drifts from the modelled sequence.
- **Policy switches mid-stream:** these expose any state that is cleared on a mode change.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

    typedef enum logic {
        SEL_IDLE  = 1'b0,
        SEL_ISSUE = 1'b1
    } sel_state_e;

endpackage

// File: rtl/vsel_lfsr.sv
module vsel_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'hA5
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);

    logic feedback;

    assign feedback = ^(state & TAPS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else begin
            state <= {state[W-2:0], feedback};
        end
    end

endmodule

// File: rtl/vsel_pick.sv
module vsel_pick #(
    parameter int WAYS = 4,
    parameter int WW   = 2
) (
    input  logic [WW-1:0]   start,
    input  logic [WAYS-1:0] lock,
    output logic            found,
    output logic [WW-1:0]   way
);

    logic [WW-1:0]   idx [WAYS];
    logic [WAYS-1:0] free;

    generate
        for (genvar k = 0; k < WAYS; k++) begin : g_off
            assign idx[k]  = start + WW'(k);
            assign free[k] = !lock[idx[k]];
        end
    endgenerate

    always_comb begin
        found = 1'b0;
        way   = start;
        for (int k = WAYS - 1; k >= 0; k--) begin
            if (free[k]) begin
                found = 1'b1;
                way   = idx[k];
            end
        end
    end

endmodule

// File: rtl/vsel_rr.sv
module vsel_rr #(
    parameter int WW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic [WW-1:0] chosen,
    output logic [WW-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= chosen + WW'(1);
        end
    end

endmodule

// File: rtl/vsel_top.sv
module vsel_top
    import vsel_pkg::*;
#(
    parameter int              WAYS   = 4,
    parameter int              LFSR_W = 8,
    parameter logic [LFSR_W-1:0] TAPS = 8'hB8,
    parameter logic [LFSR_W-1:0] SEED = 8'hA5,
    localparam int             WW     = $clog2(WAYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fill_req,
    input  logic [WAYS-1:0] lock_mask,
    input  logic            rand_mode,
    input  logic            cache_on,
    output logic [WW-1:0]   victim_way,
    output logic            victim_valid
);

    sel_state_e        state_q, state_d;
    logic [LFSR_W-1:0] lfsr;
    logic [WW-1:0]     rr_ptr;
    logic [WW-1:0]     scan_start;
    logic [WW-1:0]     pick_way;
    logic              pick_found;
    logic              accept;
    logic [WW-1:0]     way_q;

    vsel_lfsr #(.W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (lfsr)
    );

    vsel_rr #(.WW(WW)) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (accept && !rand_mode),
        .chosen  (pick_way),
        .ptr     (rr_ptr)
    );

    assign scan_start = rand_mode ? lfsr[WW-1:0] : rr_ptr;

    vsel_pick #(.WAYS(WAYS), .WW(WW)) u_pick (
        .start (scan_start),
        .lock  (lock_mask),
        .found (pick_found),
        .way   (pick_way)
    );

    assign accept = fill_req && cache_on && pick_found;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_IDLE:  state_d = accept ? SEL_ISSUE : SEL_IDLE;
            SEL_ISSUE: state_d = accept ? SEL_ISSUE : SEL_IDLE;
            default:   state_d = SEL_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            way_q <= '0;
        end else if (accept) begin
            way_q <= pick_way;
        end
    end

    assign victim_valid = (state_q == SEL_ISSUE);
    assign victim_way   = way_q;

endmodule

// File: rtl/vsel_chk.sv
module vsel_chk #(
    parameter int WAYS = 4,
    parameter int WW   = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fill_req,
    input logic [WAYS-1:0] lock_mask,
    input logic            cache_on,
    input logic [WW-1:0]   victim_way,
    input logic            victim_valid
);

    logic [WAYS-1:0] lock_q;

    always_ff @(posedge clk) begin
        lock_q <= lock_mask;
    end

    assert_locked_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> !lock_q[victim_way]);

    assert_issue_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && cache_on && lock_mask != '1) |=> victim_valid);

    assert_pulse_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> $past(fill_req));

    assert_full_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_mask == '1) |=> !victim_valid);

    assert_cache_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cache_on |=> !victim_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_req |=> !victim_valid);

endmodule

bind vsel_top vsel_chk #(.WAYS(WAYS), .WW(WW)) u_vsel_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fill_req     (fill_req),
    .lock_mask    (lock_mask),
    .cache_on     (cache_on),
    .victim_way   (victim_way),
    .victim_valid (victim_valid)
);

// File: tb/test_vsel_top.sv
`timescale 1ns/1ps
module test_vsel_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fill_req = 1'b0;
    logic [3:0] lock_mask = 4'h0;
    logic       rand_mode = 1'b0;
    logic       cache_on = 1'b1;
    logic [1:0] victim_way;
    logic       victim_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit         v;
        logic [1:0] w;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    logic [7:0] m_lfsr;
    logic [1:0] m_ptr = 2'd0;

    always #4 clk = ~clk;

    vsel_top i_vsel_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .fill_req     (fill_req),
        .lock_mask    (lock_mask),
        .rand_mode    (rand_mode),
        .cache_on     (cache_on),
        .victim_way   (victim_way),
        .victim_valid (victim_valid)
    );

    // R6 model: seed A5, shift left, new bit0 = b7^b5^b4^b3
    always @(posedge clk) begin
        if (!rst_n) m_lfsr <= 8'hA5;
        else        m_lfsr <= {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic req(input logic [3:0] lk, input bit rnd, input bit on, input string tag);
        exp_t e;
        int   start;
        int   sel;
        @(negedge clk);
        fill_req  = 1'b1;
        lock_mask = lk;
        rand_mode = rnd;
        cache_on  = on;
        sel = -1;
        start = rnd ? int'(m_lfsr[1:0]) : int'(m_ptr);
        for (int k = 0; k < 4; k++) begin
            if (sel < 0 && !lk[(start + k) % 4]) sel = (start + k) % 4;
        end
        e.tag = tag;
        if (!on || sel < 0) begin
            e.v = 1'b0;
            e.w = 2'd0;
        end else begin
            e.v = 1'b1;
            e.w = 2'(sel);
            if (!rnd) m_ptr = 2'((sel + 1) % 4);
        end
        exp_q.push_back(e);
    endtask

    task automatic idle();
        exp_t e;
        @(negedge clk);
        fill_req = 1'b0;
        e.v = 1'b0;
        e.w = 2'd0;
        e.tag = "R2";
        exp_q.push_back(e);
    endtask

    // Monitor: compare against scoreboard after each edge
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check(victim_valid == e.v, {e.tag, " valid"}, int'(victim_valid), int'(e.v));
                if (e.v)
                    check(victim_way == e.w, {e.tag, " way"}, int'(victim_way), int'(e.w));
            end
        end
    end

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL R2 watchdog expired: actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(victim_valid == 1'b0, "R1 valid in reset", int'(victim_valid), 0);
        check(victim_way == 2'd0, "R1 way in reset", int'(victim_way), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(victim_valid == 1'b0, "R1 valid after reset", int'(victim_valid), 0);
        check(victim_way == 2'd0, "R1 way after reset", int'(victim_way), 0);

        // R1/R4: round-robin, no locks, back-to-back
        req(4'h0, 1'b0, 1'b1, "R1");
        for (int i = 0; i < 5; i++) req(4'h0, 1'b0, 1'b1, "R4");
        idle();
        idle();

        // R3/R4: ways 0 and 2 locked
        for (int i = 0; i < 4; i++) req(4'b0101, 1'b0, 1'b1, "R3");
        idle();
        for (int i = 0; i < 3; i++) req(4'b1011, 1'b0, 1'b1, "R4");
        idle();

        // R7/R5: all locked, pointer must hold
        req(4'hF, 1'b0, 1'b1, "R7");
        req(4'hF, 1'b0, 1'b1, "R7");
        idle();
        req(4'h0, 1'b0, 1'b1, "R5");
        idle();

        // R8: cache off
        req(4'h0, 1'b0, 1'b0, "R8");
        req(4'h0, 1'b1, 1'b0, "R8");
        idle();
        req(4'h0, 1'b0, 1'b1, "R8");
        idle();

        // R6: random mode, several masks, gaps between requests
        for (int i = 0; i < 8; i++) begin
            req(4'h0, 1'b1, 1'b1, "R6");
            if (i % 3 == 0) idle();
        end
        for (int i = 0; i < 6; i++) req(4'b0110, 1'b1, 1'b1, "R3");
        for (int i = 0; i < 4; i++) req(4'b1110, 1'b1, 1'b1, "R6");
        idle();

        // R5/R9: random requests leave pointer alone; switches apply at once
        req(4'h0, 1'b0, 1'b1, "R9");
        req(4'h0, 1'b1, 1'b1, "R9");
        req(4'h0, 1'b1, 1'b1, "R9");
        req(4'h0, 1'b0, 1'b1, "R5");
        req(4'h0, 1'b1, 1'b1, "R9");
        idle();

        // R9: mixed stream of masks, modes and enables
        for (int i = 0; i < 48; i++) begin
            req(4'((i * 7) % 16), 1'(i % 2), (i % 5) != 0, "R9");
            if (i % 4 == 3) idle();
        end
        idle();
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule